// File: doc/BRIEF.md
# Redundant Receive Line Selector

This block sits in front of the receive decoder of a two-level serial bus. The bus has a recessive level, 1, and a dominant level, 0. Three redundant line receivers feed the block. It passes exactly one of them to the decoder. Software can pin the choice to a given receiver. In automatic mode, the block grades each receiver in two ways. It votes each receiver against the other two once per bit period. It also watches each receiver for a lack of transitions. When the bus is quiet, the block moves to the best-graded receiver.

A pulsed coding mode exists for optical or radio links. When this mode is on, the block always uses receiver 0 and stops all grading. The block exposes the chosen index and one fault flag per receiver, so the surrounding logic can read the health of each line.

A four-state controller decides how the selection is made:
- `S_FORCED`: the software choice applies.
- `S_PULSED`: receiver 0 is locked in.
- `S_HOLD`: automatic mode while a frame is in progress; the selection is frozen.
- `S_IDLE`: automatic mode while the bus is quiet; the selection follows the best grade.

The controller picks its next state from scratch on every clock:
- `pulsed_en` high leads to `S_PULSED`.
- Otherwise, `auto_en` low leads to `S_FORCED`.
- Otherwise, a quiet bus leads to `S_IDLE`.
- Otherwise, the next state is `S_HOLD`.

All four states can therefore go to every other state in one clock.

Top module: `rx_line_select`

## Requirements
- R1: `rx_out` always equals `rx_in[sel_idx]` in the same cycle, and `sel_idx` only ever holds 0, 1 or 2.
- R2: With `pulsed_en`=0 and `auto_en`=0, `sel_idx` takes the value of `force_sel` one clock later. The code 3 selects receiver 0.
- R3: With `pulsed_en`=1, `sel_idx` becomes 0 one clock later. This overrides both the software choice and automatic mode.
- R4: While `pulsed_en`=1, the vote counters and the silence counters hold their values, so the fault flags do not change.
- R5: Every BIT_CYCLES clocks a sample point occurs. At each sample point, each receiver's vote counter changes by one step:
  - It counts up by one if the other two receivers agree with each other and this receiver differs from them.
  - Otherwise it counts down by one.
  - It saturates at 0 and at 2^ERR_W-1.
- R6: `fault[i]` is 1 while receiver i is stuck or its vote counter is at least ERR_LIMIT. Bit i of `fault` belongs to `rx_in[i]`.
- R7: A receiver is stuck when it has had no transition for STUCK_BITS sample points while another receiver has had a transition within that window. Its next transition clears the stuck condition on the following clock.
- R8: The bus is quiet once the 2-of-3 majority of the receivers has stayed at 1 for IDLE_BITS sample points in a row. In automatic mode, `sel_idx` does not change while the bus is not quiet.
- R9: In automatic mode on a quiet bus, `sel_idx` moves within one clock to the receiver with the lowest grade. The grade is the vote count, and a stuck receiver grades worse than any count. On a tie, the lowest index wins.
- R10: After reset, `sel_idx` is 0, `fault` is 0 and the controller is in `S_FORCED`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 3 | Redundant receive lines, 1 = recessive |
| auto_en | input | 1 | 1 = automatic grading and selection |
| force_sel | input | 2 | Software choice of receiver (3 maps to 0) |
| pulsed_en | input | 1 | Pulsed coding active: lock to receiver 0 and stop grading |
| rx_out | output | 1 | Selected receive line to the decoder |
| sel_idx | output | 2 | Index of the selected receiver |
| fault | output | 3 | Per-receiver fault flags |

## Verification
Mode changes register once, so the bench drives `force_sel`, `pulsed_en` and `auto_en` on a falling edge and checks `sel_idx` at the falling edge after the next rising edge. `rx_out` is combinational, so the bench checks it half a cycle after it drives `rx_in`.

The grading results take longer, and their phase depends on the free-running bit timer:
- A vote fault needs ERR_LIMIT sample points.
- A stuck flag needs STUCK_BITS sample points.
- A switch needs IDLE_BITS quiet sample points plus one clock.

For these results, the bench holds each input pattern for whole bit periods, well beyond the count needed. It then checks only the settled values, so the timer phase never decides a check.

// File: rtl/rxsel_pkg.sv
package rxsel_pkg;

    localparam int LINES = 3;

    typedef enum logic [1:0] {
        S_FORCED = 2'd0,
        S_PULSED = 2'd1,
        S_HOLD   = 2'd2,
        S_IDLE   = 2'd3
    } sel_state_e;

endpackage

// File: rtl/rxsel_bit_timer.sv
module rxsel_bit_timer #(
    parameter int BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(BIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R5
endmodule

// File: rtl/rxsel_diag.sv
module rxsel_diag #(
    parameter int ERR_W      = 4,
    parameter int ERR_LIMIT  = 8,
    parameter int STUCK_BITS = 16,
    parameter int IDLE_BITS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       freeze,
    input  logic [2:0] rx,
    output logic [2:0] fault,
    output logic [1:0] best_idx,
    output logic       bus_idle
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
    localparam logic [ERR_W-1:0] ERR_LIM = ERR_W'(ERR_LIMIT);
    localparam int SW  = $clog2(STUCK_BITS + 1);
    localparam int IW  = $clog2(IDLE_BITS + 1);
    localparam int SCW = ERR_W + 1;
    localparam logic [SW-1:0] QUIET_TOP = SW'(STUCK_BITS);
    localparam logic [IW-1:0] IDLE_TOP  = IW'(IDLE_BITS);

    logic [2:0]       prev_q;
    logic [2:0]       disagree, stuck;
    logic [ERR_W-1:0] err_q   [0:2];
    logic [SW-1:0]    quiet_q [0:2];
    logic [SCW-1:0]   score   [0:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= rx;
    end

    for (genvar g = 0; g < 3; g++) begin : g_line
        localparam int A = (g + 1) % 3;
        localparam int B = (g + 2) % 3;

        assign disagree[g] = (rx[A] == rx[B]) && (rx[g] != rx[A]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                err_q[g] <= '0;
            end else if (tick && !freeze) begin
                if (disagree[g]) begin
                    if (err_q[g] != ERR_MAX) err_q[g] <= err_q[g] + 1'b1;
                end else if (err_q[g] != '0) begin
                    err_q[g] <= err_q[g] - 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                quiet_q[g] <= '0;
            end else if (!freeze) begin
                if (rx[g] != prev_q[g])                    quiet_q[g] <= '0;
                else if (tick && quiet_q[g] != QUIET_TOP)  quiet_q[g] <= quiet_q[g] + 1'b1;
            end
        end

        assign stuck[g] = (quiet_q[g] == QUIET_TOP) &&
                          ((quiet_q[A] != QUIET_TOP) || (quiet_q[B] != QUIET_TOP));
        assign fault[g] = stuck[g] || (err_q[g] >= ERR_LIM);
        assign score[g] = stuck[g] ? {SCW{1'b1}} : {1'b0, err_q[g]};

        AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[g] == ERR_MAX) |=> (err_q[g] >= ERR_MAX - 1'b1));  // R5
        AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            freeze |=> ($stable(err_q[g]) && $stable(quiet_q[g])));  // R4
    end

    logic [SCW-1:0] min01;
    always_comb begin
        if (score[1] < score[0]) begin
            best_idx = 2'd1;
            min01    = score[1];
        end else begin
            best_idx = 2'd0;
            min01    = score[0];
        end
        if (score[2] < min01) best_idx = 2'd2;
    end

    logic          majority;
    logic [IW-1:0] idle_q;

    assign majority = (rx[0] & rx[1]) | (rx[0] & rx[2]) | (rx[1] & rx[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           idle_q <= '0;
        else if (!majority)                   idle_q <= '0;
        else if (tick && idle_q != IDLE_TOP)  idle_q <= idle_q + 1'b1;
    end

    assign bus_idle = (idle_q == IDLE_TOP);
endmodule

// File: rtl/rx_line_select.sv
module rx_line_select
    import rxsel_pkg::*;
#(
    parameter int BIT_CYCLES = 16,
    parameter int ERR_W      = 4,
    parameter int ERR_LIMIT  = 8,
    parameter int STUCK_BITS = 16,
    parameter int IDLE_BITS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rx_in,
    input  logic       auto_en,
    input  logic [1:0] force_sel,
    input  logic       pulsed_en,
    output logic       rx_out,
    output logic [1:0] sel_idx,
    output logic [2:0] fault
);
    logic       tick, bus_idle;
    logic [1:0] best_idx;

    rxsel_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rxsel_diag #(
        .ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT),
        .STUCK_BITS(STUCK_BITS), .IDLE_BITS(IDLE_BITS)
    ) u_diag (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(pulsed_en),
        .rx(rx_in), .fault(fault), .best_idx(best_idx), .bus_idle(bus_idle)
    );

    sel_state_e state_q, state_nxt;
    logic [1:0] sel_q, sel_nxt;

    always_comb begin
        if (pulsed_en)     state_nxt = S_PULSED;
        else if (!auto_en) state_nxt = S_FORCED;
        else if (bus_idle) state_nxt = S_IDLE;
        else               state_nxt = S_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FORCED;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_nxt)
            S_PULSED: sel_nxt = 2'd0;
            S_FORCED: sel_nxt = (force_sel == 2'd3) ? 2'd0 : force_sel;
            S_IDLE:   sel_nxt = best_idx;
            S_HOLD:   sel_nxt = sel_q;
            default:  sel_nxt = 2'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 2'd0;
        else        sel_q <= sel_nxt;
    end

    assign sel_idx = sel_q;
    assign rx_out  = rx_in[sel_q];

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != 2'd3);  // R1
    AST_FORCED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulsed_en && !auto_en && force_sel != 2'd3) |=> (sel_idx == $past(force_sel)));  // R2
    AST_PULSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pulsed_en |=> (sel_idx == 2'd0));  // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !pulsed_en && !bus_idle) |=> $stable(sel_idx));  // R8
    AST_AUTO_FOLLOWS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULSED) |-> (sel_idx == 2'd0));  // R3
endmodule

// File: tb/rx_line_select_tb.sv
module rx_line_select_tb;
    localparam int BITC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rx_in = 3'b111;
    logic       auto_en = 1'b0;
    logic [1:0] force_sel = 2'd0;
    logic       pulsed_en = 1'b0;
    logic       rx_out;
    logic [1:0] sel_idx;
    logic [2:0] fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_line_select #(
        .BIT_CYCLES(BITC), .ERR_W(3), .ERR_LIMIT(4), .STUCK_BITS(4), .IDLE_BITS(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .auto_en(auto_en),
        .force_sel(force_sel), .pulsed_en(pulsed_en),
        .rx_out(rx_out), .sel_idx(sel_idx), .fault(fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic one_clk();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BITC) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_in = 3'b111; auto_en = 1'b0;
        force_sel = 2'd0; pulsed_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 sel after reset", sel_idx, 0);
        chk("R10 fault after reset", fault, 0);
        rx_in = 3'b110;
        #1;
        chk("R1 rx_out follows line 0", rx_out, 0);
        rx_in = 3'b111;
    endtask

    task automatic t_forced();
        do_reset();
        force_sel = 2'd2;
        one_clk();
        chk("R2 forced select 2", sel_idx, 2);
        rx_in = 3'b011;
        #1;
        chk("R1 rx_out follows line 2", rx_out, 0);
        rx_in = 3'b111;
        force_sel = 2'd1;
        one_clk();
        chk("R2 forced select 1", sel_idx, 1);
        force_sel = 2'd3;
        one_clk();
        chk("R2 code 3 maps to 0", sel_idx, 0);
    endtask

    task automatic t_tie();
        do_reset();
        auto_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rx_in = (k % 2 == 0) ? 3'b000 : 3'b111;
            wait_bits(1);
        end
        rx_in = 3'b111;
        wait_bits(4);
        chk("R9 tie picks lowest index", sel_idx, 0);
        chk("R6 no fault on agreeing lines", fault, 0);
    endtask

    task automatic t_vote();
        do_reset();
        auto_en = 1'b1;
        rx_in = 3'b110;
        wait_bits(10);
        chk("R9 switch away from outvoted line", sel_idx, 1);
        chk("R6 R5 vote fault on line 0", fault, 3'b001);
        pulsed_en = 1'b1;
        one_clk();
        chk("R3 pulsed overrides automatic", sel_idx, 0);
        pulsed_en = 1'b0;
        rx_in = 3'b111;
        wait_bits(12);
        chk("R5 counter decays, fault clears", fault, 0);
        chk("R9 back to lowest index on tie", sel_idx, 0);
    endtask

    task automatic t_busy_hold();
        do_reset();
        auto_en = 1'b1;
        rx_in = 3'b110;
        wait_bits(10);
        chk("R9 setup select line 1", sel_idx, 1);
        for (int k = 0; k < 16; k++) begin
            rx_in = (k % 2 == 0) ? 3'b010 : 3'b101;
            wait_bits(1);
        end
        chk("R8 selection held while busy", sel_idx, 1);
        chk("R6 line 1 outvoted during frame", fault[1], 1);
        rx_in = 3'b111;
        wait_bits(4);
        chk("R8 switch once quiet", sel_idx, 0);
    endtask

    task automatic t_stuck();
        do_reset();
        auto_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rx_in = (k % 2 == 0) ? 3'b100 : 3'b111;
            wait_bits(1);
        end
        chk("R7 silent line 2 flagged", fault, 3'b100);
        for (int k = 0; k < 2; k++) begin
            rx_in = (k % 2 == 0) ? 3'b000 : 3'b111;
            wait_bits(1);
        end
        chk("R7 transition clears stuck", fault, 0);
    endtask

    task automatic t_pulsed();
        do_reset();
        force_sel = 2'd2;
        one_clk();
        chk("R2 setup forced 2", sel_idx, 2);
        pulsed_en = 1'b1;
        one_clk();
        chk("R3 pulsed locks line 0", sel_idx, 0);
        rx_in = 3'b110;
        #1;
        chk("R1 pulsed output is line 0", rx_out, 0);
        wait_bits(10);
        chk("R4 grading frozen while pulsed", fault, 0);
        chk("R3 still line 0", sel_idx, 0);
    endtask

    initial begin
        t_reset();
        t_forced();
        t_tie();
        t_vote();
        t_busy_hold();
        t_stuck();
        t_pulsed();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule